// File: doc/BRIEF.md
# Consecutive-Silence Auto-Mute for Six Audio Channels

This block watches a frame of signed samples, one per channel, on each frame strobe. When every channel has carried silence for a long unbroken run of frames, it raises one mute flag that covers all channel outputs together. A silent sample is either the all-zeros code or the all-ones code (minus one). One frame in which any channel carries another value clears the run and lowers the flag.

An enable input switches the auto-mute feature on and off. Lowering the enable releases an auto-mute at once and clears the run. A separate clock-fault input raises the mute in the same cycle, whatever the enable is. That mute holds while the fault stays high and clears on the first frame strobe that arrives after the fault has dropped.

The run threshold is set by a parameter. The default is 512 frames, which is the low end of the allowed 512 to 1024 frame window.

Top module: `zero_run_automute`

## Requirements
- R1: After reset `mute_out` is 0 and the silent-frame run count is 0.
- R2: A sample is silent only when all its SAMPLE_W bits are equal: all 0 (zero) or all 1 (minus one). Any other code, such as +1, -2, the most negative value or the most positive value, is not silent.
- R3: With the enable high and the fault low, `mute_out` rises right after the clock edge that captures the RUN_FRAMES-th consecutive frame in which all channels are silent. After RUN_FRAMES-1 such frames it is still 0.
- R4: A captured frame in which at least one channel is not silent resets the run to 0 and releases an auto-mute after that edge. A full new run of RUN_FRAMES silent frames is then needed to mute again.
- R5: Samples presented while `frame_valid` is 0 are ignored and leave the run count unchanged.
- R6: While `automute_en` is 0, the auto-mute is released combinationally and the run is held at 0, so silence never mutes. After the enable goes high again, a fresh run is needed.
- R7: `clk_fault` high drives `mute_out` high in the same cycle, whatever the enable and the run state.
- R8: After `clk_fault` falls, `mute_out` stays high until the first frame strobe captured with the fault low. It then follows the auto-mute alone.
- R9: The run count saturates at RUN_FRAMES. Silence that continues past the threshold keeps `mute_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe; frame_samples holds a frame |
| frame_samples | input | NUM_CH*SAMPLE_W | Channel c occupies bits [c*SAMPLE_W +: SAMPLE_W] |
| automute_en | input | 1 | Enables the consecutive-silence mute |
| clk_fault | input | 1 | Clock-source error; forces mute |
| mute_out | output | 1 | Global mute for all channels |

## Verification
A table of frame patterns is applied, each repeated for a full threshold run. The patterns are all zeros, all minus one, zeros mixed with minus one, and one channel carrying +1, -2, the most negative or the most positive code. Together they separate a test for "all bits equal" from a test for zero only, and they show that one loud channel among silent ones is enough to hold the mute off. Directed runs of RUN_FRAMES-1 and RUN_FRAMES frames pin the threshold to the exact frame. Non-strobed loud samples show that unstrobed data is ignored. Enable toggling and fault pulses show the order in which release and override take effect.

// File: rtl/zra_pkg.sv
package zra_pkg;
  localparam int MAX_W = 64;

  // A code is silent when every bit in its width matches bit 0.
  function automatic logic silent_code(input logic [MAX_W-1:0] value, input int width);
    logic same;
    same = 1'b1;
    for (int i = 1; i < MAX_W; i++) begin
      if (i < width && value[i] != value[0]) same = 1'b0;
    end
    return same;
  endfunction
endpackage

// File: rtl/zra_silence_det.sv
module zra_silence_det #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic                       all_silent
);
  import zra_pkg::*;

  logic [NUM_CH-1:0] ch_silent;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MAX_W-1:0] widened;
    always_comb begin
      widened = '0;
      widened[SAMPLE_W-1:0] = samples[c*SAMPLE_W +: SAMPLE_W];
      ch_silent[c] = silent_code(widened, SAMPLE_W);
    end
  end

  assign all_silent = &ch_silent;
endmodule

// File: rtl/zra_run_counter.sv
module zra_run_counter #(
  parameter int RUN_FRAMES = 512,
  localparam int CNT_W = $clog2(RUN_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             all_silent,
  input  logic             enable,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_full
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_FRAMES);

  assign run_full = (run_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!enable) begin
      run_cnt <= '0;
    end else if (frame_valid) begin
      if (!all_silent) run_cnt <= '0;
      else if (!run_full) run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/zra_mute_ctrl.sv
module zra_mute_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_valid,
  input  logic enable,
  input  logic run_full,
  input  logic clk_fault,
  output logic fault_hold,
  output logic auto_mute,
  output logic mute
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_hold <= 1'b0;
    else if (clk_fault) fault_hold <= 1'b1;
    else if (frame_valid) fault_hold <= 1'b0;
  end

  assign auto_mute = enable & run_full;
  assign mute      = clk_fault | fault_hold | auto_mute;
endmodule

// File: rtl/zero_run_automute.sv
module zero_run_automute #(
  parameter int NUM_CH     = 6,
  parameter int SAMPLE_W   = 24,
  parameter int RUN_FRAMES = 512,
  localparam int CNT_W = $clog2(RUN_FRAMES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] frame_samples,
  input  logic                       automute_en,
  input  logic                       clk_fault,
  output logic                       mute_out
);
  logic             all_silent;
  logic [CNT_W-1:0] run_cnt;
  logic             run_full;
  logic             fault_hold;
  logic             auto_mute;

  zra_silence_det #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_det (
    .samples    (frame_samples),
    .all_silent (all_silent)
  );

  zra_run_counter #(.RUN_FRAMES(RUN_FRAMES)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .all_silent  (all_silent),
    .enable      (automute_en),
    .run_cnt     (run_cnt),
    .run_full    (run_full)
  );

  zra_mute_ctrl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .enable      (automute_en),
    .run_full    (run_full),
    .clk_fault   (clk_fault),
    .fault_hold  (fault_hold),
    .auto_mute   (auto_mute),
    .mute        (mute_out)
  );
endmodule

// File: rtl/zero_run_automute_chk.sv
module zero_run_automute_chk #(
  parameter int RUN_FRAMES = 512,
  localparam int CNT_W = $clog2(RUN_FRAMES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             automute_en,
  input logic             clk_fault,
  input logic             mute_out,
  input logic             all_silent,
  input logic [CNT_W-1:0] run_cnt,
  input logic             run_full,
  input logic             fault_hold,
  input logic             auto_mute
);
  p_fault_mutes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fault |-> mute_out);

  p_loud_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !all_silent) |=> (run_cnt == '0));

  p_disable_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !automute_en |-> !auto_mute);

  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && automute_en) |=> $stable(run_cnt));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(RUN_FRAMES));

  p_full_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_full) |-> $past(frame_valid && all_silent));

  p_fault_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_hold) |-> $past(frame_valid && !clk_fault));
endmodule

bind zero_run_automute zero_run_automute_chk #(.RUN_FRAMES(RUN_FRAMES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .automute_en (automute_en),
  .clk_fault   (clk_fault),
  .mute_out    (mute_out),
  .all_silent  (all_silent),
  .run_cnt     (run_cnt),
  .run_full    (run_full),
  .fault_hold  (fault_hold),
  .auto_mute   (auto_mute)
);

// File: tb/zero_run_automute_bench.sv
module zero_run_automute_bench;
  localparam int NUM_CH = 6;
  localparam int SW     = 24;
  localparam int RUN    = 512;
  localparam int NVEC   = 8;

  // vector: {base[23:0], odd channel[2:0], odd value[23:0], expect mute}
  localparam logic [51:0] VEC [NVEC] = '{
    {24'h000000, 3'd0, 24'h000000, 1'b1},
    {24'hFFFFFF, 3'd0, 24'hFFFFFF, 1'b1},
    {24'h000000, 3'd4, 24'hFFFFFF, 1'b1},
    {24'hFFFFFF, 3'd3, 24'h000001, 1'b0},
    {24'h000000, 3'd5, 24'hFFFFFE, 1'b0},
    {24'h000000, 3'd0, 24'h800000, 1'b0},
    {24'hFFFFFF, 3'd2, 24'h7FFFFF, 1'b0},
    {24'h000000, 3'd1, 24'h000100, 1'b0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic fv = 0;
  logic [NUM_CH*SW-1:0] smp = '0;
  logic en = 1;
  logic fault = 0;
  logic mute;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zero_run_automute u_zero_run_automute (
    .clk(clk), .rst_n(rst_n), .frame_valid(fv), .frame_samples(smp),
    .automute_en(en), .clk_fault(fault), .mute_out(mute)
  );

  function automatic logic [NUM_CH*SW-1:0] build(input logic [SW-1:0] base,
      input int idx, input logic [SW-1:0] odd);
    logic [NUM_CH*SW-1:0] r;
    for (int c = 0; c < NUM_CH; c++) r[c*SW +: SW] = (c == idx) ? odd : base;
    return r;
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (mute !== exp) begin
      fails++;
      $display("FAIL %s: mute_out=%b expected %b", req, mute, exp);
    end
  endtask

  task automatic frame(input logic [NUM_CH*SW-1:0] d);
    @(negedge clk);
    fv = 1; smp = d;
    @(negedge clk);
    fv = 0;
  endtask

  task automatic frames(input int n, input logic [NUM_CH*SW-1:0] d);
    for (int i = 0; i < n; i++) frame(d);
  endtask

  localparam logic [NUM_CH*SW-1:0] QUIET = '0;
  logic [NUM_CH*SW-1:0] loud;

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    loud = build(24'h0, 4, 24'h000003);
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 1'b0);

    // R2/R3: table of silence patterns, each for a full run
    for (int v = 0; v < NVEC; v++) begin
      frames(RUN, build(VEC[v][51:28], int'(VEC[v][27:25]), VEC[v][24:1]));
      check($sformatf("R2 vector %0d", v), VEC[v][0]);
      frame(loud);
      check($sformatf("R4 release after vector %0d", v), 1'b0);
    end

    // R3 exact threshold
    frames(RUN - 1, QUIET);
    check("R3 one frame short", 1'b0);
    frame(QUIET);
    check("R3 at threshold", 1'b1);

    // R9 saturation
    frames(50, QUIET);
    check("R9 beyond threshold", 1'b1);

    // R4 one loud channel restarts run
    frame(loud);
    check("R4 loud frame releases", 1'b0);
    frames(RUN - 1, QUIET);
    check("R4 run restarted", 1'b0);

    // R5 unstrobed loud samples ignored
    @(negedge clk);
    smp = loud;
    repeat (20) @(negedge clk);
    check("R5 idle no mute yet", 1'b0);
    frame(QUIET);
    check("R5 run survived idle loud data", 1'b1);

    // R6 enable low releases at once and clears run
    en = 0;
    #1;
    check("R6 immediate release", 1'b0);
    @(negedge clk);
    en = 1;
    #1;
    check("R6 run cleared", 1'b0);
    en = 0;
    frames(RUN + 5, QUIET);
    check("R6 disabled never mutes", 1'b0);
    en = 1;
    frames(RUN - 1, QUIET);
    check("R6 fresh run needed", 1'b0);

    // R7 fault forces mute, enable low too
    en = 0;
    @(negedge clk);
    fault = 1;
    #1;
    check("R7 fault immediate", 1'b1);
    frame(loud);
    check("R7 frame during fault", 1'b1);

    // R8 hold until first frame after fault drops
    @(negedge clk);
    fault = 0;
    repeat (5) @(negedge clk);
    check("R8 held after fault drops", 1'b1);
    frame(loud);
    check("R8 released on frame", 1'b0);

    // R8 with enable high and full run: mute stays from auto path
    en = 1;
    frames(RUN, QUIET);
    @(negedge clk);
    fault = 1;
    @(negedge clk);
    fault = 0;
    frame(QUIET);
    check("R8 auto mute remains after fault release", 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule